// File: doc/BRIEF.md
# Keyed Overlay Logic Mixer

This block merges a 24-bit RGB pixel stream with one of three programmable overlay colors. A 2-bit key picks, for each pixel, either the plain video or one of the colors. For each non-zero key, a 2-bit operation code sets how the color is applied: it replaces the video, or it is combined with the video by bitwise AND, OR or XOR. The key comes from external pins (brought in through a two-flop synchronizer), from an on-screen-display key input that wins whenever it is non-zero, or from a register field that forces a fixed key for test.

Each color channel also has a 256-entry, 8-bit gamma lookup table with its own enable. When the routing bit is set, key 11 sends the video through the tables instead of applying the operation for key 11. A channel whose enable is clear passes its byte through unchanged. All settings, and the table contents, are written through a byte write port. Table writes may happen while pixels stream; the pipeline never stalls.

Top module: `ovl_mixer`

## Requirements
- R1: Pixels use R in bits 23:16, G in 15:8 and B in 7:0. Key 00 outputs the pixel unchanged, 4 clock cycles after it is presented at `pix_in`.
- R2: Keys 01, 10 and 11 select overlay colors 1, 2 and 3. Operation code 00 replaces the pixel with that color.
- R3: The mode register (address 0) holds the operation codes for keys 01, 10 and 11 in bits 1:0, 3:2 and 5:4. Code 01 gives pixel AND color, 10 gives pixel OR color, and 11 gives pixel XOR color.
- R4: After reset, color 1 is (0,0,255), color 2 is (255,255,0) and color 3 is (255,0,0). Color k, channel c (0=R, 1=G, 2=B) is written at address 5+3*(k-1)+c.
- R5: When mode bit 7 is set and the key is 11, the pixel goes through the lookup tables and the operation code for key 11 is ignored. Keys 01 and 10 keep their operations.
- R6: Table-control register (address 1) bits 0, 1 and 2 enable the R, G and B tables. A channel whose bit is clear outputs its input byte on the table path.
- R7: Table-control bits 5:4 select the table to write: 00 R, 01 G, 10 B, 11 none. Address 2 sets the entry index. A write to address 3 stores the data byte at that index in the selected table.
- R8: The force register (address 4) bits 1:0, when non-zero, replace the hardware key for every pixel. The value 00 uses the hardware key.
- R9: The hardware key is `osd_key` when that input is non-zero, and otherwise `key_pins`. Both are sampled with the pixel they go with and stay aligned with it through the pipeline.
- R10: A table write lands in the same cycle as a read of the same entry. The read returns the old value. Writes never stall or drop pixels.
- R11: Reset clears `pix_out`, the mode register, the table control and the force field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pix_in | input | 24 | Input pixel, R in the top byte |
| key_pins | input | 2 | External overlay key |
| osd_key | input | 2 | On-screen-display key, wins when non-zero |
| pix_out | output | 24 | Mixed pixel, 4 cycles after input |

## Verification
A wrong key in the aligned pipeline shows up 4 cycles later as a pixel taking the color or operation of a neighbouring key. A corrupt operation field or color register shows as wrong bits on every pixel with that key, and the very first such pixel exposes it. A table entry that is written to the wrong channel or index, or an enable bit that is wired to the wrong channel, only shows when that exact byte value passes under key 11 with routing on. For this reason all 256 values are swept per channel under each enable pattern. The same-entry write collision is placed in the exact read cycle, so returning the new data, or dropping the write, changes the very next output.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
  typedef enum logic [1:0] {
    OP_REPL = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_XOR  = 2'b11
  } ovl_op_e;

  localparam int NUM_CH  = 3;
  localparam int NUM_KEY = 3;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] A_MODE   = 4'd0;
  localparam logic [ADDR_W-1:0] A_LUTCTL = 4'd1;
  localparam logic [ADDR_W-1:0] A_LUTIDX = 4'd2;
  localparam logic [ADDR_W-1:0] A_LUTDAT = 4'd3;
  localparam logic [ADDR_W-1:0] A_FORCE  = 4'd4;
  localparam int                A_COL0   = 5;

  localparam int ROUTE_BIT = 7;
endpackage

// File: rtl/ovl_cfg_regs.sv
`timescale 1ns/1ps
module ovl_cfg_regs
  import ovl_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [CH_W-1:0]                 wdata,
  output logic [7:0]                      mode_q,
  output logic [NUM_CH-1:0]               lut_en,
  output logic [1:0]                      force_key,
  output logic [CH_W-1:0]                 lut_idx,
  output logic [NUM_CH-1:0]               lut_we,
  output logic [CH_W-1:0]                 lut_wdata,
  output logic [NUM_KEY*NUM_CH*CH_W-1:0]  colors_flat
);
  localparam int NCOL = NUM_KEY * NUM_CH;

  logic [CH_W-1:0] col_q [NCOL];
  logic [1:0]      lut_sel;

  // color 1 blue, color 2 yellow, color 3 red; slot = (key-1)*3 + channel
  function automatic logic [CH_W-1:0] col_default(int slot);
    return ((slot == 2) || (slot == 3) || (slot == 4) || (slot == 6)) ? '1 : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      lut_en    <= '0;
      lut_sel   <= '0;
      force_key <= '0;
      lut_idx   <= '0;
      for (int i = 0; i < NCOL; i++) col_q[i] <= col_default(i);
    end else if (we) begin
      case (addr)
        A_MODE:   mode_q    <= wdata[7:0];
        A_LUTCTL: begin
          lut_en  <= wdata[NUM_CH-1:0];
          lut_sel <= wdata[5:4];
        end
        A_LUTIDX: lut_idx   <= wdata;
        A_FORCE:  force_key <= wdata[1:0];
        default: begin
          if (int'(addr) >= A_COL0 && int'(addr) < A_COL0 + NCOL)
            col_q[int'(addr) - A_COL0] <= wdata;
        end
      endcase
    end
  end

  assign lut_wdata = wdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign lut_we[c] = we && (addr == A_LUTDAT) && (lut_sel == 2'(c));
  end

  for (genvar i = 0; i < NCOL; i++) begin : g_flat
    assign colors_flat[i*CH_W +: CH_W] = col_q[i];
  end
endmodule

// File: rtl/ovl_key_align.sv
`timescale 1ns/1ps
module ovl_key_align #(
  parameter int PIX_W  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [1:0]       key_pins,
  input  logic [1:0]       osd_key,
  output logic [PIX_W-1:0] pix_al,
  output logic [1:0]       key_al
);
  logic [PIX_W-1:0] pix_d [STAGES];
  logic [1:0]       pin_d [STAGES];
  logic [1:0]       osd_d [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        pix_d[i] <= '0;
        pin_d[i] <= '0;
        osd_d[i] <= '0;
      end
    end else begin
      pix_d[0] <= pix_in;
      pin_d[0] <= key_pins;
      osd_d[0] <= osd_key;
      for (int i = 1; i < STAGES; i++) begin
        pix_d[i] <= pix_d[i-1];
        pin_d[i] <= pin_d[i-1];
        osd_d[i] <= osd_d[i-1];
      end
    end
  end

  assign pix_al = pix_d[STAGES-1];
  assign key_al = (osd_d[STAGES-1] != 2'b00) ? osd_d[STAGES-1] : pin_d[STAGES-1];
endmodule

// File: rtl/ovl_gamma_lut.sv
`timescale 1ns/1ps
module ovl_gamma_lut #(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CH_W-1:0] waddr,
  input  logic [CH_W-1:0] wdata,
  input  logic [CH_W-1:0] raddr,
  output logic [CH_W-1:0] rdata
);
  localparam int DEPTH = 1 << CH_W;

  logic [CH_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read: a same-cycle write to this entry is seen one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/ovl_mixer.sv
`timescale 1ns/1ps
module ovl_mixer
  import ovl_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [CH_W-1:0]        cfg_wdata,
  input  logic [NUM_CH*CH_W-1:0] pix_in,
  input  logic [1:0]             key_pins,
  input  logic [1:0]             osd_key,
  output logic [NUM_CH*CH_W-1:0] pix_out
);
  localparam int PIX_W       = NUM_CH * CH_W;
  localparam int SYNC_STAGES = 2;

  logic [7:0]                     mode_q;
  logic [NUM_CH-1:0]              lut_en;
  logic [1:0]                     force_key;
  logic [CH_W-1:0]                lut_idx;
  logic [NUM_CH-1:0]              lut_we;
  logic [CH_W-1:0]                lut_wdata;
  logic [NUM_KEY*NUM_CH*CH_W-1:0] colors_flat;

  logic [PIX_W-1:0] vid_al, vid_s3, lut_q, pix_next;
  logic [1:0]       key_al, key_sel, key_s3, op_s3;
  logic             route_s3;

  function automatic logic [CH_W-1:0] apply_op(ovl_op_e op, logic [CH_W-1:0] v,
                                               logic [CH_W-1:0] c);
    case (op)
      OP_AND:  return v & c;
      OP_OR:   return v | c;
      OP_XOR:  return v ^ c;
      default: return c;
    endcase
  endfunction

  ovl_cfg_regs #(.CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode_q(mode_q), .lut_en(lut_en), .force_key(force_key), .lut_idx(lut_idx),
    .lut_we(lut_we), .lut_wdata(lut_wdata), .colors_flat(colors_flat)
  );

  ovl_key_align #(.PIX_W(PIX_W), .STAGES(SYNC_STAGES)) u_align (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .key_pins(key_pins),
    .osd_key(osd_key), .pix_al(vid_al), .key_al(key_al)
  );

  assign key_sel = (force_key != 2'b00) ? force_key : key_al;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_s3 <= '0;
      key_s3 <= '0;
    end else begin
      vid_s3 <= vid_al;
      key_s3 <= key_sel;
    end
  end

  always_comb begin
    case (key_s3)
      2'd1:    op_s3 = mode_q[1:0];
      2'd2:    op_s3 = mode_q[3:2];
      2'd3:    op_s3 = mode_q[5:4];
      default: op_s3 = 2'b00;
    endcase
  end
  assign route_s3 = (key_s3 == 2'd3) && mode_q[ROUTE_BIT];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int SLOT = (NUM_CH - 1 - g) * CH_W;
    logic [CH_W-1:0] ch_out;

    ovl_gamma_lut #(.CH_W(CH_W)) u_lut (
      .clk(clk), .rst_n(rst_n), .we(lut_we[g]), .waddr(lut_idx),
      .wdata(lut_wdata), .raddr(vid_al[SLOT +: CH_W]), .rdata(lut_q[SLOT +: CH_W])
    );

    always_comb begin
      ch_out = vid_s3[SLOT +: CH_W];
      if (key_s3 != 2'b00) begin
        if (route_s3)
          ch_out = lut_en[g] ? lut_q[SLOT +: CH_W] : vid_s3[SLOT +: CH_W];
        else
          ch_out = apply_op(ovl_op_e'(op_s3), vid_s3[SLOT +: CH_W],
                     colors_flat[((int'(key_s3) - 1) * NUM_CH + g) * CH_W +: CH_W]);
      end
    end
    assign pix_next[SLOT +: CH_W] = ch_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= pix_next;
  end
endmodule

// File: rtl/ovl_mixer_chk.sv
`timescale 1ns/1ps
module ovl_mixer_chk
  import ovl_pkg::*;
#(
  parameter int CH_W = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH*CH_W-1:0]         pix_out,
  input logic [NUM_CH*CH_W-1:0]         vid_s3,
  input logic [1:0]                     key_s3,
  input logic [7:0]                     mode_q,
  input logic [NUM_CH-1:0]              lut_en,
  input logic [1:0]                     force_key,
  input logic [NUM_KEY*NUM_CH*CH_W-1:0] colors_flat
);
  logic [NUM_CH*CH_W-1:0] col1_pix, col2_pix;
  assign col1_pix = {colors_flat[0*CH_W +: CH_W], colors_flat[1*CH_W +: CH_W],
                     colors_flat[2*CH_W +: CH_W]};
  assign col2_pix = {colors_flat[3*CH_W +: CH_W], colors_flat[4*CH_W +: CH_W],
                     colors_flat[5*CH_W +: CH_W]};

  assert_key0_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (key_s3 == 2'b00) |=> (pix_out == $past(vid_s3)));

  assert_replace_c1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_s3 == 2'b01 && mode_q[1:0] == 2'b00) |=> (pix_out == $past(col1_pix)));

  assert_xor_c2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_s3 == 2'b10 && mode_q[3:2] == 2'b11) |=> (pix_out == $past(vid_s3 ^ col2_pix)));

  assert_lut_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_s3 == 2'b11 && mode_q[7] && lut_en == '0) |=> (pix_out == $past(vid_s3)));

  assert_force_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_key != 2'b00) |=> (key_s3 == $past(force_key)));
endmodule

bind ovl_mixer ovl_mixer_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_out(pix_out), .vid_s3(vid_s3), .key_s3(key_s3),
  .mode_q(mode_q), .lut_en(lut_en), .force_key(force_key), .colors_flat(colors_flat)
);

// File: tb/ovl_mixer_bench.sv
`timescale 1ns/1ps
module ovl_mixer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] pix_in = '0;
  logic [1:0]  key_pins = '0;
  logic [1:0]  osd_key = '0;
  logic [23:0] pix_out;

  always #10 clk = ~clk;

  ovl_mixer u_ovl_mixer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_in(pix_in), .key_pins(key_pins),
    .osd_key(osd_key), .pix_out(pix_out)
  );

  int nvec = 0;
  int nbad = 0;

  // bench copy of the configuration, built from the requirements
  logic [7:0]  mode_b = 8'h00;
  logic [2:0]  en_b   = 3'b000;
  logic [1:0]  fb     = 2'b00;
  logic [23:0] col_b [1:3];
  logic [7:0]  blut  [3][256];

  logic [23:0] pe [4];
  bit          pv [4];
  string       pr [4];

  function automatic logic [7:0] lut_formula(int ch, int x);
    return 8'((x * (2 * ch + 3) + 17 * ch + 1) & 255);
  endfunction

  function automatic logic [23:0] emix(int k, logic [23:0] v);
    logic [23:0] c;
    logic [23:0] r;
    int op;
    if (k == 0) return v;
    if (k == 3 && mode_b[7]) begin
      for (int ch = 0; ch < 3; ch++) begin
        logic [7:0] b;
        b = v[23 - 8*ch -: 8];
        r[23 - 8*ch -: 8] = en_b[ch] ? blut[ch][b] : b;
      end
      return r;
    end
    c  = col_b[k];
    op = (int'(mode_b) >> (2 * (k - 1))) % 4;
    case (op)
      0: r = c;
      1: r = v & c;
      2: r = v | c;
      default: r = v ^ c;
    endcase
    return r;
  endfunction

  task automatic check(logic [23:0] exp, string rq);
    nvec++;
    if (pix_out !== exp) begin
      nbad++;
      $display("FAIL %s: pix_out got %h expected %h", rq, pix_out, exp);
    end
  endtask

  task automatic step(bit v, logic [23:0] px, logic [1:0] pk, logic [1:0] ok,
                      string rq, bit we = 1'b0, logic [3:0] a = 4'h0,
                      logic [7:0] d = 8'h00);
    int k;
    @(negedge clk);
    if (pv[3]) check(pe[3], pr[3]);
    for (int i = 3; i > 0; i--) begin
      pe[i] = pe[i-1]; pv[i] = pv[i-1]; pr[i] = pr[i-1];
    end
    k = (fb != 0) ? int'(fb) : ((ok != 0) ? int'(ok) : int'(pk));
    pv[0] = v; pr[0] = rq; pe[0] = emix(k, px);
    pix_in = px; key_pins = pk; osd_key = ok;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
  endtask

  task automatic flush();
    repeat (5) step(1'b0, 24'h0, 2'b00, 2'b00, "");
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(1'b0, 24'h0, 2'b00, 2'b00, "", 1'b1, a, d);
  endtask

  task automatic set_col(int k, logic [23:0] rgb);
    for (int ch = 0; ch < 3; ch++) wr(4'(5 + 3 * (k - 1) + ch), rgb[23 - 8*ch -: 8]);
    col_b[k] = rgb;
  endtask

  initial begin
    #4000000;
    nbad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  logic [15:0] lf = 16'hACE1;
  function automatic logic [15:0] lf_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    logic [23:0] vids [4];
    vids[0] = 24'h000000; vids[1] = 24'hFFFFFF; vids[2] = 24'h5AA53C; vids[3] = 24'hC3183E;
    col_b[1] = 24'h0000FF; col_b[2] = 24'hFFFF00; col_b[3] = 24'hFF0000;
    for (int ch = 0; ch < 3; ch++)
      for (int x = 0; x < 256; x++) blut[ch][x] = lut_formula(ch, x);
    for (int i = 0; i < 4; i++) begin pv[i] = 0; pe[i] = '0; pr[i] = ""; end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(24'h000000, "R11 reset output");

    // R4 default colors, replace (mode 0 after reset, R11)
    for (int k = 1; k < 4; k++) step(1'b1, 24'h5AA53C, 2'(k), 2'b00, "R4/R2 default color");
    flush();

    set_col(1, 24'h123456);
    set_col(2, 24'hA5C30F);
    set_col(3, 24'hF0F00F);

    // R2/R3 every operation combination on every key
    for (int m = 0; m < 64; m++) begin
      flush();
      wr(4'h0, 8'(m));
      mode_b = 8'(m);
      for (int k = 1; k < 4; k++)
        for (int i = 0; i < 4; i++)
          step(1'b1, vids[i], 2'(k), 2'b00, "R3/R2 op sweep");
    end

    // R9/R1 mixed key sources, changing every pixel
    flush();
    wr(4'h0, 8'b0011_1001);
    mode_b = 8'b0011_1001;
    for (int n = 0; n < 300; n++) begin
      lf = lf_next(lf);
      step(1'b1, {lf[7:0], lf[15:8], lf[11:4]}, lf[1:0], (lf[5:4] == 2'b11) ? lf[3:2] : 2'b00,
           "R9/R1 key alignment");
    end

    // R8 forced key overrides pins and osd
    flush();
    wr(4'h4, 8'h02);
    fb = 2'b10;
    for (int n = 0; n < 40; n++) begin
      lf = lf_next(lf);
      step(1'b1, {lf, lf[7:0]}, lf[1:0], lf[3:2], "R8 forced key");
    end
    flush();
    wr(4'h4, 8'h00);
    fb = 2'b00;

    // R7 program all three tables
    for (int ch = 0; ch < 3; ch++) begin
      wr(4'h1, 8'(ch << 4));
      for (int x = 0; x < 256; x++) begin
        wr(4'h2, 8'(x));
        wr(4'h3, lut_formula(ch, x));
      end
    end
    // R7 select 11 writes no table
    wr(4'h1, 8'h30);
    wr(4'h2, 8'h00);
    wr(4'h3, 8'hEE);

    // R5/R6 every enable pattern, all byte values, op3 field set to XOR but ignored
    wr(4'h0, 8'hB9);
    mode_b = 8'hB9;
    for (int e = 0; e < 8; e++) begin
      flush();
      wr(4'h1, 8'h30 | 8'(e));
      en_b = 3'(e);
      for (int x = 0; x < 256; x++)
        step(1'b1, {8'(x), 8'(x) ^ 8'h5A, ~8'(x)}, 2'b11, 2'b00, "R5/R6/R7 table path");
      step(1'b1, 24'h3C3C3C, 2'b01, 2'b00, "R5 key 01 keeps op");
      step(1'b1, 24'h3C3C3C, 2'b10, 2'b00, "R5 key 10 keeps op");
    end

    // R10 write to the entry being read in the same cycle
    flush();
    wr(4'h1, 8'h07);
    en_b = 3'b111;
    wr(4'h2, 8'h40);
    step(1'b1, 24'h40_40_40, 2'b11, 2'b00, "R10 old value on collision");
    step(1'b1, 24'h01_02_03, 2'b11, 2'b00, "R10 stream continues");
    step(1'b1, 24'h04_05_06, 2'b11, 2'b00, "R10 stream continues", 1'b1, 4'h3, 8'h3C);
    blut[0][8'h40] = 8'h3C;
    step(1'b1, 24'h07_08_09, 2'b11, 2'b00, "R10 stream continues");
    flush();
    step(1'b1, 24'h40_40_40, 2'b11, 2'b00, "R10 new value after write");
    flush();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule